// File: doc/BRIEF.md
# Register Block Mover

This block carries out one multi-register transfer between a sixteen-entry register file and memory. Entries 0 to 7 are the data registers and entries 8 to 15 are the address registers. A 16-bit selection mask names the registers taking part. On a `start` pulse the block takes the direction, the transfer size (16-bit word or 32-bit long), the addressing mode, the base address register number and the start address. It then issues one bus cycle per selected register and waits for an acknowledge on each. It reads register values through a combinational read port and writes them through a single write port. The register file itself sits outside the block.

There are three addressing modes. Control mode walks upward from the start address and writes nothing back. Increment mode walks upward in the same way and, at the end, writes the final advanced address into the base register. Decrement mode reverses the mask: mask bit i selects register 15-i, registers are visited from the highest down, and the address is reduced before each access. At the end the base register receives the address of the last access. The start address arrives already computed, and a start pulse while busy is ignored.

Top module: `regblk_mover`

## Requirements
- R1: In control or increment mode, mask bit i selects register i (bits 0-7 data registers, bits 8-15 address registers). Selected registers are moved lowest index first, with the first access at the start address and later accesses at rising addresses.
- R2: Each access moves 2 bytes when `size_long` is 0 and 4 bytes when it is 1, and consecutive accesses differ by exactly that many bytes. `mem_long` reports the size.
- R3: In decrement mode, mask bit i selects register 15-i (bit 0 is address register 7), registers are moved highest index first, and each access address is the previous address minus the size, starting from start address minus the size.
- R4: At the end of a decrement-mode transfer, register 8+`base_reg` is written with the address of the last access.
- R5: A word load writes the register with bits 15:0 of `mem_rdata` sign-extended to 32 bits. A word store drives the register's bits 15:0 on `mem_wdata` with bits 31:16 zero. Long transfers move all 32 bits.
- R6: At the end of an increment-mode transfer, register 8+`base_reg` is written with the start address plus the size times the number of selected registers. This write comes after, and overrides, any value loaded into that register.
- R7: In a decrement-mode store that selects the base register, the value stored for it is its value before the transfer.
- R8: An all-zero mask causes no bus request, and `done` rises in the cycle after `start` is taken.
- R9: `done` is high for exactly one cycle, the cycle after the acknowledge of the last bus cycle.
- R10: `mem_req` holds `mem_addr` and `mem_we` steady until `mem_ack`, and it is low whenever `busy` is low.
- R11: Control mode never writes back an address to the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (taken when not busy) |
| to_mem | input | 1 | 1: registers to memory, 0: memory to registers |
| size_long | input | 1 | 1: 32-bit transfers, 0: 16-bit transfers |
| amode | input | 2 | 0 control, 1 increment, 2 decrement (3 acts as control) |
| base_reg | input | 3 | Address register number used for write-back |
| reg_mask | input | 16 | Register selection mask |
| start_addr | input | 32 | First address (byte) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Bus cycle request |
| mem_we | output | 1 | Bus cycle is a write |
| mem_long | output | 1 | Bus cycle is 32-bit |
| mem_addr | output | 32 | Bus byte address |
| mem_wdata | output | 32 | Bus write data |
| mem_rdata | input | 32 | Bus read data |
| mem_ack | input | 1 | Bus cycle complete |
| rf_rd_idx | output | 4 | Register file read index |
| rf_rd_data | input | 32 | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_wr_idx | output | 4 | Register file write index |
| rf_wr_data | output | 32 | Register file write data |

## Verification
The bench targets the decrement-mode mask reversal. A design that kept the normal bit order would store the wrong registers, in the wrong order, at the wrong addresses. It checks a load into the base register under increment mode, where a missing or early write-back would leave the loaded memory value in place of the final address. A decrement store that includes the base register would expose a design that wrote the already-decremented address. Word loads with bit 15 set, an empty mask and acknowledge latencies of zero to several cycles catch, in turn, missing sign extension, a request or a late `done` on an empty transfer, and addresses that move before the acknowledge.

// File: rtl/regblk_pkg.sv
// Shared types for the register block mover.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package regblk_pkg;

    // Sequencer state.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2
    } mv_state_e;

    // Addressing mode encoding on the amode port.
    typedef enum logic [1:0] {
        AM_CTRL = 2'd0,
        AM_INC  = 2'd1,
        AM_DEC  = 2'd2,
        AM_RSVD = 2'd3
    } mv_amode_e;

endpackage

// File: rtl/regblk_pick.sv
// Picks the next register from a pending mask.
// from_top=0 returns the lowest set bit, from_top=1 the highest.
// Assumes: the caller ignores idx when pend is all zero.
module regblk_pick #(
    parameter int IW = 4,
    localparam int N = 1 << IW
) (
    input  logic [N-1:0]  pend,
    input  logic          from_top,
    output logic [IW-1:0] idx
);

    // Priority scan; the last hit in the loop wins.
    always_comb begin
        idx = '0;
        if (!from_top) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (pend[i]) idx = IW'(i);
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (pend[i]) idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/regblk_addr.sv
// Address stepper: gives the address for the current access and the
// address to hold after it completes.
// Assumes: word size HW bits, long size DW bits, both whole bytes.
module regblk_addr #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic          dec,
    input  logic          is_long,
    output logic [AW-1:0] access,
    output logic [AW-1:0] next
);

    localparam int HBYTES = HW / 8;
    localparam int LBYTES = DW / 8;

    logic [AW-1:0] step;

    // Byte step per access.
    always_comb step = is_long ? AW'(LBYTES) : AW'(HBYTES);

    // Decrement: reduce first, then access. Otherwise access, then advance.
    always_comb begin
        if (dec) begin
            access = cur - step;
            next   = cur - step;
        end else begin
            access = cur;
            next   = cur + step;
        end
    end

endmodule

// File: rtl/regblk_fmt.sv
// Data formatting between register width and bus transfer size.
// Word stores zero the upper bits; word loads sign-extend bit HW-1.
// Assumes: HW < DW.
module regblk_fmt #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic          is_long,
    input  logic [DW-1:0] reg_in,
    input  logic [DW-1:0] mem_in,
    output logic [DW-1:0] st_data,
    output logic [DW-1:0] ld_data
);

    // Store path.
    always_comb st_data = is_long ? reg_in : {{(DW-HW){1'b0}}, reg_in[HW-1:0]};

    // Load path.
    always_comb ld_data = is_long ? mem_in : {{(DW-HW){mem_in[HW-1]}}, mem_in[HW-1:0]};

endmodule

// File: rtl/regblk_mover.sv
// Register block mover: sequences one bus cycle per selected register
// between an external register file and memory, then optionally writes
// the final address back to the base address register.
// Assumes: the register file read port is combinational; mem_ack may
// arrive in the same cycle as mem_req; start is ignored while busy.
module regblk_mover
    import regblk_pkg::*;
#(
    parameter int IW = 4,
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 to_mem,
    input  logic                 size_long,
    input  logic [1:0]           amode,
    input  logic [IW-2:0]        base_reg,
    input  logic [(1<<IW)-1:0]   reg_mask,
    input  logic [AW-1:0]        start_addr,
    output logic                 busy,
    output logic                 done,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic                 mem_long,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic [DW-1:0]        mem_rdata,
    input  logic                 mem_ack,
    output logic [IW-1:0]        rf_rd_idx,
    input  logic [DW-1:0]        rf_rd_data,
    output logic                 rf_we,
    output logic [IW-1:0]        rf_wr_idx,
    output logic [DW-1:0]        rf_wr_data
);

    localparam int NREG = 1 << IW;

    mv_state_e       state_q;
    logic [NREG-1:0] pend_q;
    logic [AW-1:0]   addr_q;
    logic            to_mem_q;
    logic            long_q;
    logic            dec_q;
    logic            wb_q;
    logic [IW-2:0]   base_q;

    logic [NREG-1:0] mask_rev;
    logic [NREG-1:0] mask_in;
    logic            dec_in;
    logic            wb_in;
    logic [IW-1:0]   pick_idx;
    logic [NREG-1:0] pick_oh;
    logic [NREG-1:0] pend_nx;
    logic [AW-1:0]   acc_addr;
    logic [AW-1:0]   nxt_addr;
    logic [DW-1:0]   st_data;
    logic [DW-1:0]   ld_data;

    // Reversed mask for decrement mode: bit g selects register NREG-1-g.
    for (genvar g = 0; g < NREG; g++) begin : g_rev
        assign mask_rev[g] = reg_mask[NREG-1-g];
    end

    // Mode decode at start.
    always_comb begin
        dec_in  = (amode == AM_DEC);
        wb_in   = (amode == AM_DEC) || (amode == AM_INC);
        mask_in = dec_in ? mask_rev : reg_mask;
    end

    regblk_pick #(.IW(IW)) u_pick (
        .pend     (pend_q),
        .from_top (dec_q),
        .idx      (pick_idx)
    );

    regblk_addr #(.AW(AW), .DW(DW), .HW(HW)) u_addr (
        .cur     (addr_q),
        .dec     (dec_q),
        .is_long (long_q),
        .access  (acc_addr),
        .next    (nxt_addr)
    );

    regblk_fmt #(.DW(DW), .HW(HW)) u_fmt (
        .is_long (long_q),
        .reg_in  (rf_rd_data),
        .mem_in  (mem_rdata),
        .st_data (st_data),
        .ld_data (ld_data)
    );

    // Pending mask after the current register completes.
    always_comb begin
        pick_oh = NREG'(1) << pick_idx;
        pend_nx = pend_q & ~pick_oh;
    end

    // Sequencer state, pending mask and address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pend_q   <= '0;
            addr_q   <= '0;
            to_mem_q <= 1'b0;
            long_q   <= 1'b0;
            dec_q    <= 1'b0;
            wb_q     <= 1'b0;
            base_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pend_q   <= mask_in;
                        addr_q   <= start_addr;
                        to_mem_q <= to_mem;
                        long_q   <= size_long;
                        dec_q    <= dec_in;
                        wb_q     <= wb_in;
                        base_q   <= base_reg;
                        state_q  <= (reg_mask == '0) ? ST_FIN : ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (mem_ack) begin
                        pend_q <= pend_nx;
                        addr_q <= nxt_addr;
                        if (pend_nx == '0) state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Bus side outputs.
    always_comb begin
        mem_req   = (state_q == ST_XFER);
        mem_we    = to_mem_q;
        mem_long  = long_q;
        mem_addr  = acc_addr;
        mem_wdata = st_data;
        rf_rd_idx = pick_idx;
    end

    // Register file write: load data on ack, address write-back at the end.
    always_comb begin
        if (state_q == ST_FIN) begin
            rf_we      = wb_q;
            rf_wr_idx  = {1'b1, base_q};
            rf_wr_data = DW'(addr_q);
        end else begin
            rf_we      = (state_q == ST_XFER) && mem_ack && !to_mem_q;
            rf_wr_idx  = pick_idx;
            rf_wr_data = ld_data;
        end
    end

    // Status outputs.
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_FIN);
    end

endmodule

// File: rtl/regblk_mover_chk.sv
// Protocol checker for regblk_mover, bound to every instance.
// Assumes: byte step of 2 (word) or 4 (long).
module regblk_mover_chk #(
    parameter int IW = 4,
    parameter int AW = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [1:0]         amode,
    input logic               size_long,
    input logic [(1<<IW)-1:0] reg_mask,
    input logic               mem_req,
    input logic               mem_ack,
    input logic               mem_we,
    input logic [AW-1:0]      mem_addr,
    input logic               rf_we
);

    logic          c_dec_q;
    logic          c_ctrl_q;
    logic [AW-1:0] c_step_q;
    logic          c_acked_q;
    logic [AW-1:0] c_prev_q;

    // Mode and step of the transfer in progress, plus the last acked address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_dec_q   <= 1'b0;
            c_ctrl_q  <= 1'b0;
            c_step_q  <= '0;
            c_acked_q <= 1'b0;
            c_prev_q  <= '0;
        end else begin
            if (start && !busy) begin
                c_dec_q  <= (amode == 2'd2);
                c_ctrl_q <= (amode == 2'd0) || (amode == 2'd3);
                c_step_q <= size_long ? AW'(4) : AW'(2);
            end
            c_acked_q <= mem_req && mem_ack;
            c_prev_q  <= mem_addr;
        end
    end

    // R2 R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && c_acked_q) |->
            (mem_addr == (c_dec_q ? c_prev_q - c_step_q : c_prev_q + c_step_q)));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done));

    // R8
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (reg_mask == '0)) |=> (done && !mem_req));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (done || mem_req));

    // R11
    ctrl_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_ctrl_q) |-> !rf_we);

endmodule

bind regblk_mover regblk_mover_chk #(.IW(IW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .amode     (amode),
    .size_long (size_long),
    .reg_mask  (reg_mask),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .rf_we     (rf_we)
);

// File: tb/regblk_mover_tb_top.sv
// Bench: behavioural reference model (queues of expected bus cycles and
// register writes) compared against the design on every clock.
module regblk_mover_tb_top;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        to_mem = 1'b0;
    logic        size_long = 1'b0;
    logic [1:0]  amode = 2'd0;
    logic [2:0]  base_reg = 3'd0;
    logic [15:0] reg_mask = 16'h0;
    logic [31:0] start_addr = 32'h0;
    logic        busy, done, mem_req, mem_we, mem_long;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 32'h0;
    logic        mem_ack = 1'b0;
    logic [3:0]  rf_rd_idx;
    logic [31:0] rf_rd_data;
    logic        rf_we;
    logic [3:0]  rf_wr_idx;
    logic [31:0] rf_wr_data;

    logic [31:0] rf [16];

    typedef struct packed {
        logic [31:0] a;
        logic        we;
        logic [31:0] d;
    } bus_t;

    typedef struct packed {
        logic [3:0]  idx;
        logic [31:0] d;
    } wr_t;

    bus_t exp_bus[$];
    wr_t  exp_wr[$];

    int  n_vec = 0;
    int  n_bad = 0;
    bit  summary_done = 0;

    always #(CLK_NS/2) clk = ~clk;

    assign rf_rd_data = rf[rf_rd_idx];

    regblk_mover dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .to_mem(to_mem),
        .size_long(size_long), .amode(amode), .base_reg(base_reg),
        .reg_mask(reg_mask), .start_addr(start_addr), .busy(busy),
        .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_long(mem_long), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .rf_rd_idx(rf_rd_idx),
        .rf_rd_data(rf_rd_data), .rf_we(rf_we), .rf_wr_idx(rf_wr_idx),
        .rf_wr_data(rf_wr_data)
    );

    // Memory content as a function of address.
    function automatic logic [31:0] memval(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h1357_8000;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        end
    endtask

    // One complete transfer with reference model and per-cycle compare.
    task automatic run_op(input string tag, input bit tm, input bit lg,
                          input logic [1:0] md, input logic [2:0] bs,
                          input logic [15:0] mk, input logic [31:0] sa,
                          input int lat);
        logic [31:0] a = sa;
        logic [31:0] st = lg ? 32'd4 : 32'd2;
        bit dec = (md == 2'd2);
        bit exp_done = 0;
        bit seen_done = 0;
        int waitc = 0;
        logic [31:0] lv;
        exp_bus.delete();
        exp_wr.delete();
        for (int k = 0; k < 16; k++) begin
            logic [3:0] r = dec ? 4'(15 - k) : 4'(k);
            if (mk[k]) begin
                if (dec) a = a - st;
                if (tm) begin
                    exp_bus.push_back('{a: a, we: 1'b1,
                        d: lg ? rf[r] : {16'h0, rf[r][15:0]}});
                end else begin
                    lv = memval(a);
                    exp_bus.push_back('{a: a, we: 1'b0, d: 32'h0});
                    exp_wr.push_back('{idx: r,
                        d: lg ? lv : {{16{lv[15]}}, lv[15:0]}});
                end
                if (!dec) a = a + st;
            end
        end
        if (md == 2'd1 || md == 2'd2) exp_wr.push_back('{idx: {1'b1, bs}, d: a});

        @(negedge clk);
        start = 1'b1; to_mem = tm; size_long = lg; amode = md;
        base_reg = bs; reg_mask = mk; start_addr = sa;
        #1;
        check(!mem_req && !done && !busy, "R10", "idle before start", {29'h0, mem_req, done, busy}, 32'h0);
        exp_done = (mk == 16'h0);

        for (int cyc = 0; cyc < 400 && !seen_done; cyc++) begin
            bit nd = 0;
            @(negedge clk);
            start = 1'b0;
            mem_ack = 1'b0;
            if (mem_req) begin
                if (waitc >= lat) begin
                    mem_ack = 1'b1;
                    waitc = 0;
                end else begin
                    waitc++;
                end
            end
            mem_rdata = memval(mem_addr);
            #1;
            // R9 R8: done exactly one cycle after the last ack (or after start)
            check(done == exp_done, exp_done ? tag : "R9", "done timing", {31'h0, done}, {31'h0, exp_done});
            if (done) seen_done = 1;
            if (mem_req) begin
                if (exp_bus.size() == 0) begin
                    check(0, "R10", "unexpected request", mem_addr, 32'h0);
                end else begin
                    check(mem_addr == exp_bus[0].a, tag, "address", mem_addr, exp_bus[0].a);
                    check(mem_we == exp_bus[0].we, tag, "direction", {31'h0, mem_we}, {31'h0, exp_bus[0].we});
                    check(mem_long == lg, "R2", "size", {31'h0, mem_long}, {31'h0, lg});
                    if (exp_bus[0].we)
                        check(mem_wdata == exp_bus[0].d, tag, "store data", mem_wdata, exp_bus[0].d);
                    if (mem_ack) begin
                        void'(exp_bus.pop_front());
                        nd = (exp_bus.size() == 0);
                    end
                end
            end
            if (rf_we) begin
                if (exp_wr.size() == 0) begin
                    check(0, tag, "unexpected register write", {28'h0, rf_wr_idx}, 32'h0);
                end else begin
                    check(rf_wr_idx == exp_wr[0].idx, tag, "write index", {28'h0, rf_wr_idx}, {28'h0, exp_wr[0].idx});
                    check(rf_wr_data == exp_wr[0].d, tag, "write data", rf_wr_data, exp_wr[0].d);
                    void'(exp_wr.pop_front());
                end
                rf[rf_wr_idx] = rf_wr_data;
            end
            exp_done = nd;
        end
        check(seen_done, tag, "transfer completed", {31'h0, seen_done}, 32'h1);
        check(exp_bus.size() == 0 && exp_wr.size() == 0, tag, "all expected activity seen",
              exp_bus.size() + exp_wr.size(), 32'h0);
        if (md == 2'd1 || md == 2'd2)
            check(rf[{1'b1, bs}] == a, dec ? "R4" : "R6", "final base register", rf[{1'b1, bs}], a);
        @(negedge clk);
        #1;
        check(!done && !busy, "R9", "done is one cycle", {30'h0, done, busy}, 32'h0);
        mem_ack = 1'b0;
    endtask

    // Watchdog.
    initial begin
        #(CLK_NS * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    // Main sequence.
    initial begin
        for (int i = 0; i < 16; i++)
            rf[i] = 32'hC0DE_0000 + 32'(i) * 32'h0101_9111;
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !done && !mem_req && !rf_we, "R10", "reset state",
              {28'h0, busy, done, mem_req, rf_we}, 32'h0);
        rst_n = 1'b1;

        // R1 R11: control store, long, both ends of the mask
        run_op("R1", 1'b1, 1'b1, 2'd0, 3'd0, 16'h8181, 32'h0000_1000, 0);
        // R5: control store, word, with wait states
        run_op("R5", 1'b1, 1'b0, 2'd0, 3'd1, 16'h00F0, 32'h0000_2002, 2);
        // R6: increment load, word, base register A3 also loaded
        run_op("R6", 1'b0, 1'b0, 2'd1, 3'd3, 16'h0F0F, 32'h0000_3000, 1);
        // R2: increment load, long, all registers
        run_op("R2", 1'b0, 1'b1, 2'd1, 3'd7, 16'hFFFF, 32'h0000_4000, 0);
        // R3: decrement store, bit 0 is address register 7
        run_op("R3", 1'b1, 1'b1, 2'd2, 3'd2, 16'h0001, 32'h0000_5000, 0);
        // R7: decrement store, word, base A6 (bit 1) selected
        run_op("R7", 1'b1, 1'b0, 2'd2, 3'd6, 16'hC003, 32'h0000_6000, 3);
        // R4: decrement store, long, mixed mask
        run_op("R4", 1'b1, 1'b1, 2'd2, 3'd4, 16'h5A3C, 32'h0000_7000, 1);
        // R8: empty mask in increment mode
        run_op("R8", 1'b0, 1'b1, 2'd1, 3'd5, 16'h0000, 32'h0000_8000, 0);
        // R11: empty mask in control mode, no write-back
        run_op("R11", 1'b1, 1'b0, 2'd0, 3'd5, 16'h0000, 32'h0000_9000, 0);
        // R5: control load, long then word with sign bits
        run_op("R5", 1'b0, 1'b1, 2'd0, 3'd0, 16'h1248, 32'h0000_A000, 2);
        run_op("R5", 1'b0, 1'b0, 2'd0, 3'd0, 16'h8421, 32'h0000_B00E, 0);
        // R10: back-to-back with long waits
        run_op("R10", 1'b1, 1'b0, 2'd1, 3'd2, 16'h0300, 32'h0000_C000, 5);

        summary();
        $finish;
    end

endmodule